// File: doc/BRIEF.md
# Interrupt priority and service tracker

This block is the decision core of an eight-line interrupt controller. It keeps the in-service and mask state of the eight lines and reads the pending-request bits from an external request register. From these it decides whether a request may be raised to the processor. When the processor acknowledges, the block records the winning line as in service, tells the request register which bit to drop, and hands over an interrupt number. That number is a 5-bit configured base followed by the 3-bit line index.

Priority is held as a ring. A 3-bit pointer names the lowest-priority line, and the line after it in the ring is the highest. End-of-interrupt commands arrive as decoded strobes with a 3-bit line field. The block supports:
- non-specific and specific clearing;
- optional rotation of the ring on a clear;
- explicit placement of the lowest-priority line;
- a special mask mode that lets masked in-service lines stop blocking;
- an automatic-clear mode that can also rotate on every acknowledge;
- a poll acknowledge that returns a status byte instead of an interrupt number.

Both interrupt numbers and poll results leave through one valid/ready output. A result is held, unchanged, until the consumer raises ready in a cycle where valid is high. While a result is waiting, new acknowledge and poll strobes are ignored. Ready has no other effect.

Top module: `irq_prio_core`

## Requirements
- R1: After reset, the in-service and mask registers are zero, the interrupt output and the output valid are low, and the lowest-priority pointer is 7. Line 0 is therefore the highest priority, and an acknowledge with all eight lines requesting returns line 0.
- R2: `int_o` is high, in the same cycle, exactly when some request bit is set and unmasked and no in-service line of equal or higher ring priority blocks it. Priority order starts at pointer+1 and wraps modulo 8.
- R3: An acknowledge (`ack_i`) taken while no result is pending selects the highest-priority eligible line L. In that same cycle it drives `req_clr_o` one-hot on bit L. After the next clock edge, in-service bit L is set and the output holds `{base_i, L}`. If `ack_i` and `poll_i` are both high, the acknowledge is taken.
- R4: An acknowledge taken when no line is eligible outputs `{base_i, 3'b111}`. It leaves the in-service register unchanged and drives `req_clr_o` to zero.
- R5: `vec_valid_o` stays high, with `vec_data_o` stable, until a cycle with `vec_ready_i` high. While it is high, `ack_i` and `poll_i` change neither state nor output.
- R6: A non-specific clear (`eoi_i` high, `eoi_spec_i` low) clears the in-service bit of highest ring priority, or does nothing if none is set. A specific clear (`eoi_spec_i` high) clears bit `cmd_line_i`. In a cycle that also sets a bit, the clear is applied first and the set second.
- R7: A clear with `eoi_rot_i` high moves the pointer to the line it cleared. `setlow_i` moves the pointer to `cmd_line_i`. If several pointer updates occur in one cycle, `setlow_i` wins over a rotating clear, which wins over an automatic-clear rotation.
- R8: With `smm_i` high, an in-service line whose mask bit is set does not block requests. With `smm_i` low, it does.
- R9: With `aeoi_i` high, an acknowledge sets no in-service bit. If `aeoi_rot_i` is also high, the pointer moves to the acknowledged line.
- R10: A poll (`poll_i`) with an eligible line L outputs 8'h80|L, sets in-service bit L and clears request bit L. With no eligible line it outputs 8'h00 and changes nothing. Automatic-clear mode does not apply to polls.
- R11: `mask_we_i` loads `mask_wdata_i` into the mask on the next edge, and `mask_o` shows the mask. A masked request neither raises `int_o` nor wins, and its request bit is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Pending request bits from the request register |
| req_clr_o | output | 8 | One-hot request bit to drop at the next edge |
| base_i | input | 5 | Interrupt number base (upper five bits) |
| smm_i | input | 1 | Special mask mode enable |
| aeoi_i | input | 1 | Automatic-clear mode enable |
| aeoi_rot_i | input | 1 | Rotate on each automatic clear |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask write data, 1 = masked |
| mask_o | output | 8 | Current mask |
| isr_o | output | 8 | Current in-service bits |
| int_o | output | 1 | Interrupt request to the processor |
| ack_i | input | 1 | Acknowledge strobe |
| poll_i | input | 1 | Poll acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_spec_i | input | 1 | Clear the line named by cmd_line_i |
| eoi_rot_i | input | 1 | Rotate priority on this clear |
| setlow_i | input | 1 | Make cmd_line_i the lowest priority |
| cmd_line_i | input | 3 | Line field for commands |
| vec_valid_o | output | 1 | Result valid |
| vec_data_o | output | 8 | Interrupt number or poll status |
| vec_ready_i | input | 1 | Consumer ready |

## Verification
`int_o` and `req_clr_o` are combinational. They are due in the same cycle as the stimulus, so the bench samples them after inputs settle and before the rising edge. In-service, mask, pointer and the valid/ready output each pass through one register and are due after that edge. The bench compares them at the following falling edge against a model it advances at that same point. Any effect of the pointer shows only through the next acknowledge or interrupt decision, one further cycle on.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LINE_W  = 3;
  localparam int VBASE_W = 5;
endpackage

// File: rtl/irq_rot_pick.sv
// Finds the first set bit scanning from low_i+1 around the ring.
module irq_rot_pick #(
  parameter int LW = 3
) (
  input  logic [(1<<LW)-1:0] cand_i,
  input  logic [LW-1:0]      low_i,
  output logic               hit_o,
  output logic [LW-1:0]      line_o,
  output logic [LW-1:0]      rank_o
);
  localparam int NL = 1 << LW;

  logic [LW-1:0] idx;

  always_comb begin
    hit_o  = 1'b0;
    line_o = '0;
    rank_o = '0;
    idx    = '0;
    for (int k = 0; k < NL; k++) begin
      idx = low_i + LW'(k + 1);
      if (!hit_o && cand_i[idx]) begin
        hit_o  = 1'b1;
        line_o = idx;
        rank_o = LW'(k);
      end
    end
  end
endmodule

// File: rtl/irq_line_dec.sv
// Line index to one-hot, gated by an enable.
module irq_line_dec #(
  parameter int LW = 3
) (
  input  logic               en_i,
  input  logic [LW-1:0]      line_i,
  output logic [(1<<LW)-1:0] oh_o
);
  localparam int NL = 1 << LW;

  for (genvar g = 0; g < NL; g++) begin : g_bit
    assign oh_o[g] = en_i && (line_i == LW'(g));
  end
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
  import irq_pkg::*;
#(
  parameter int LW     = LINE_W,
  parameter int BASE_W = VBASE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [(1<<LW)-1:0]   req_i,
  output logic [(1<<LW)-1:0]   req_clr_o,
  input  logic [BASE_W-1:0]    base_i,
  input  logic                 smm_i,
  input  logic                 aeoi_i,
  input  logic                 aeoi_rot_i,
  input  logic                 mask_we_i,
  input  logic [(1<<LW)-1:0]   mask_wdata_i,
  output logic [(1<<LW)-1:0]   mask_o,
  output logic [(1<<LW)-1:0]   isr_o,
  output logic                 int_o,
  input  logic                 ack_i,
  input  logic                 poll_i,
  input  logic                 eoi_i,
  input  logic                 eoi_spec_i,
  input  logic                 eoi_rot_i,
  input  logic                 setlow_i,
  input  logic [LW-1:0]        cmd_line_i,
  output logic                 vec_valid_o,
  output logic [BASE_W+LW-1:0] vec_data_o,
  input  logic                 vec_ready_i
);
  localparam int NL    = 1 << LW;
  localparam int VW    = BASE_W + LW;
  localparam int PAD_W = VW - 1 - LW;

  logic [NL-1:0] isr_q, mask_q;
  logic [LW-1:0] low_q;
  logic          vv_q;
  logic [VW-1:0] vd_q;

  // candidate requests, blocking in-service lines, all in-service lines
  logic [NL-1:0] cand_v, blk_v;
  logic          c_hit, b_hit, e_hit;
  logic [LW-1:0] c_line, c_rank, b_line, b_rank, e_line, e_rank;

  assign cand_v = req_i & ~mask_q;
  assign blk_v  = isr_q & ~(smm_i ? mask_q : '0);

  irq_rot_pick #(.LW(LW)) u_cand (
    .cand_i(cand_v), .low_i(low_q),
    .hit_o(c_hit), .line_o(c_line), .rank_o(c_rank));

  irq_rot_pick #(.LW(LW)) u_blk (
    .cand_i(blk_v), .low_i(low_q),
    .hit_o(b_hit), .line_o(b_line), .rank_o(b_rank));

  irq_rot_pick #(.LW(LW)) u_svc (
    .cand_i(isr_q), .low_i(low_q),
    .hit_o(e_hit), .line_o(e_line), .rank_o(e_rank));

  logic elig, take, grant, ack_win;
  assign elig    = c_hit && (!b_hit || (c_rank < b_rank));
  assign take    = !vv_q && (ack_i || poll_i);
  assign grant   = take && elig;
  assign ack_win = grant && ack_i;

  logic [NL-1:0] win_oh, eoi_oh, isr_set;
  logic [LW-1:0] eoi_line;
  logic          eoi_go;

  assign eoi_line = eoi_spec_i ? cmd_line_i : e_line;
  assign eoi_go   = eoi_i && (eoi_spec_i || e_hit);

  irq_line_dec #(.LW(LW)) u_win_dec (.en_i(grant),  .line_i(c_line),   .oh_o(win_oh));
  irq_line_dec #(.LW(LW)) u_eoi_dec (.en_i(eoi_go), .line_i(eoi_line), .oh_o(eoi_oh));

  assign isr_set = (ack_win && aeoi_i) ? '0 : win_oh;

  logic [VW-1:0] ack_data, poll_data;
  assign ack_data  = {base_i, (elig ? c_line : {LW{1'b1}})};
  assign poll_data = elig ? {1'b1, {PAD_W{1'b0}}, c_line} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      mask_q <= '0;
      low_q  <= {LW{1'b1}};
      vv_q   <= 1'b0;
      vd_q   <= '0;
    end else begin
      isr_q <= (isr_q & ~eoi_oh) | isr_set;
      if (mask_we_i) mask_q <= mask_wdata_i;
      if (setlow_i)                              low_q <= cmd_line_i;
      else if (eoi_go && eoi_rot_i)              low_q <= eoi_line;
      else if (ack_win && aeoi_i && aeoi_rot_i)  low_q <= c_line;
      if (take) begin
        vv_q <= 1'b1;
        vd_q <= ack_i ? ack_data : poll_data;
      end else if (vec_ready_i) begin
        vv_q <= 1'b0;
      end
    end
  end

  assign int_o       = elig;
  assign req_clr_o   = win_oh;
  assign isr_o       = isr_q;
  assign mask_o      = mask_q;
  assign vec_valid_o = vv_q;
  assign vec_data_o  = vd_q;
endmodule

// File: rtl/irq_prio_core_chk.sv
module irq_prio_core_chk #(
  parameter int LW     = 3,
  parameter int BASE_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [(1<<LW)-1:0]   req_i,
  input logic [(1<<LW)-1:0]   req_clr_o,
  input logic                 aeoi_i,
  input logic [(1<<LW)-1:0]   mask_o,
  input logic [(1<<LW)-1:0]   isr_o,
  input logic                 int_o,
  input logic                 ack_i,
  input logic                 eoi_i,
  input logic                 vec_valid_o,
  input logic [BASE_W+LW-1:0] vec_data_o,
  input logic                 vec_ready_i
);
  AST_INT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((req_i & ~mask_o) != '0)); // R2

  AST_CLR_FROM_LIVE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_clr_o & ~(req_i & ~mask_o)) == '0)); // R11

  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_clr_o)); // R3

  AST_GRANT_SETS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_clr_o != '0) && !aeoi_i && !eoi_i |=> ((isr_o & $past(req_clr_o)) != '0)); // R3

  AST_SPURIOUS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && !vec_valid_o && !int_o |=> (vec_data_o[LW-1:0] == {LW{1'b1}})); // R4

  AST_SPURIOUS_NO_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && !vec_valid_o && !int_o && !eoi_i |=> (isr_o == $past(isr_o))); // R4

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o && !vec_ready_i |=> vec_valid_o && $stable(vec_data_o)); // R5

  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && aeoi_i && !vec_valid_o && !eoi_i |=> (isr_o == $past(isr_o))); // R9
endmodule

bind irq_prio_core irq_prio_core_chk #(.LW(LW), .BASE_W(BASE_W)) u_chk (.*);

// File: tb/irq_prio_core_tb.sv
module irq_prio_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_i = '0, req_clr_o, mask_wdata_i = '0, mask_o, isr_o;
  logic [4:0] base_i = 5'h11;
  logic       smm_i = 0, aeoi_i = 0, aeoi_rot_i = 0, mask_we_i = 0;
  logic       int_o, ack_i = 0, poll_i = 0, eoi_i = 0, eoi_spec_i = 0, eoi_rot_i = 0;
  logic       setlow_i = 0, vec_valid_o, vec_ready_i = 0;
  logic [2:0] cmd_line_i = '0;
  logic [7:0] vec_data_o;

  irq_prio_core dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_isr = '0, m_mask = '0, m_req = '0, m_vd = '0;
  logic [2:0] m_low = 3'd7;
  logic       m_vv = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int prio_of(input int line, input logic [2:0] low);
    return (line + 7 - int'(low)) % 8;
  endfunction

  // {found, line} of the eligible request, by ring rank arithmetic
  function automatic logic [3:0] m_pick(input logic [7:0] isr, input logic [7:0] mask,
                                        input logic [7:0] req, input logic [2:0] low, input logic smm);
    int best = 8;
    logic [2:0] ln = '0;
    for (int i = 0; i < 8; i++)
      if (req[i] && !mask[i] && prio_of(i, low) < best) begin
        best = prio_of(i, low); ln = 3'(i);
      end
    if (best == 8) return 4'd0;
    for (int i = 0; i < 8; i++)
      if (isr[i] && !(smm && mask[i]) && prio_of(i, low) <= best) return 4'd0;
    return {1'b1, ln};
  endfunction

  function automatic logic [3:0] m_top_svc(input logic [7:0] isr, input logic [2:0] low);
    int best = 8;
    logic [2:0] ln = '0;
    for (int i = 0; i < 8; i++)
      if (isr[i] && prio_of(i, low) < best) begin
        best = prio_of(i, low); ln = 3'(i);
      end
    return {(best != 8), ln};
  endfunction

  task automatic set_req(input logic [7:0] v);
    m_req = v;
    req_i = v;
  endtask

  task automatic step(input string tag);
    logic [3:0] pk, te;
    logic       take, grant, ackw, eg, nvv;
    logic [7:0] oh, set_v, clr_v, nd, nmask;
    logic [2:0] el, nlow;
    #1;
    pk = m_pick(m_isr, m_mask, m_req, m_low, smm_i);
    chk(tag, "int_o", int_o, pk[3]);
    take  = !m_vv && (ack_i || poll_i);
    grant = take && pk[3];
    ackw  = grant && ack_i;
    oh    = grant ? (8'd1 << pk[2:0]) : 8'd0;
    chk(tag, "req_clr_o", req_clr_o, oh);
    set_v = (ackw && aeoi_i) ? 8'd0 : oh;
    te    = m_top_svc(m_isr, m_low);
    el    = eoi_spec_i ? cmd_line_i : te[2:0];
    eg    = eoi_i && (eoi_spec_i || te[3]);
    clr_v = eg ? (8'd1 << el) : 8'd0;
    nlow  = m_low;
    if (setlow_i) nlow = cmd_line_i;
    else if (eg && eoi_rot_i) nlow = el;
    else if (ackw && aeoi_i && aeoi_rot_i) nlow = pk[2:0];
    nvv = m_vv; nd = m_vd;
    if (take) begin
      nvv = 1'b1;
      if (ack_i) nd = {base_i, (pk[3] ? pk[2:0] : 3'd7)};
      else       nd = pk[3] ? {5'b10000, pk[2:0]} : 8'h00;
    end else if (vec_ready_i) nvv = 1'b0;
    nmask = mask_we_i ? mask_wdata_i : m_mask;
    @(posedge clk);
    @(negedge clk);
    m_isr = (m_isr & ~clr_v) | set_v;
    m_mask = nmask; m_low = nlow; m_vv = nvv; m_vd = nd;
    m_req = m_req & ~oh;
    req_i = m_req;
    ack_i = 0; poll_i = 0; eoi_i = 0; setlow_i = 0; mask_we_i = 0; vec_ready_i = 0;
    #1;
    chk(tag, "isr_o", isr_o, m_isr);
    chk(tag, "mask_o", mask_o, m_mask);
    chk(tag, "vec_valid_o", vec_valid_o, m_vv);
    if (m_vv) chk(tag, "vec_data_o", vec_data_o, m_vd);
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "isr_o", isr_o, 0);
    chk("R1", "mask_o", mask_o, 0);
    chk("R1", "int_o", int_o, 0);
    chk("R1", "vec_valid_o", vec_valid_o, 0);
    // R1 line 0 wins with all requesting
    set_req(8'hFF); ack_i = 1; step("R1");
    chk("R1", "first vector", vec_data_o, {5'h11, 3'd0});
    vec_ready_i = 1; step("R5");
    eoi_i = 1; step("R6");
    set_req(8'h00); step("R1");

    // R4 spurious: request vanishes before acknowledge
    set_req(8'h08); step("R2");
    set_req(8'h00); ack_i = 1; step("R4");
    chk("R4", "spurious vector", vec_data_o, {5'h11, 3'd7});
    vec_ready_i = 1; step("R4");

    // R5 hold while not ready; second ack ignored
    set_req(8'h06); ack_i = 1; step("R5");
    ack_i = 1; step("R5");
    poll_i = 1; step("R5");
    chk("R5", "held vector", vec_data_o, {5'h11, 3'd1});
    vec_ready_i = 1; step("R5");
    eoi_i = 1; eoi_spec_i = 1; cmd_line_i = 3'd1; step("R6");
    eoi_spec_i = 0;
    set_req(8'h00); step("R6");

    // R8 special mask mode
    set_req(8'h02); ack_i = 1; step("R8");
    vec_ready_i = 1; step("R8");
    set_req(8'h10); mask_we_i = 1; mask_wdata_i = 8'h02; step("R11");
    chk("R8", "blocked without smm", int_o, 0);
    smm_i = 1; step("R8");
    chk("R8", "passes with smm", int_o, 1);
    smm_i = 0; step("R8");
    mask_we_i = 1; mask_wdata_i = 8'h00; eoi_i = 1; step("R6");
    set_req(8'h00); step("R6");

    // R11 full mask keeps requests
    set_req(8'h81); mask_we_i = 1; mask_wdata_i = 8'hFF; step("R11");
    ack_i = 1; step("R11");
    chk("R11", "req kept", m_req, 8'h81);
    vec_ready_i = 1; mask_we_i = 1; mask_wdata_i = 8'h00; step("R11");
    set_req(8'h00); step("R11");

    // R9 auto clear with rotation
    aeoi_i = 1; aeoi_rot_i = 1;
    set_req(8'h04); ack_i = 1; step("R9");
    vec_ready_i = 1; step("R9");
    set_req(8'h0A); ack_i = 1; step("R9");
    chk("R9", "rotated winner", vec_data_o, {5'h11, 3'd3});
    vec_ready_i = 1; step("R9");
    aeoi_i = 0; aeoi_rot_i = 0;
    setlow_i = 1; cmd_line_i = 3'd7; set_req(8'h00); step("R7");

    // R10 poll
    poll_i = 1; step("R10");
    chk("R10", "empty poll", vec_data_o, 8'h00);
    vec_ready_i = 1; step("R10");
    set_req(8'h20); poll_i = 1; step("R10");
    chk("R10", "poll line", vec_data_o, 8'h85);
    vec_ready_i = 1; step("R10");
    eoi_i = 1; step("R6");

    // Sweep: every pointer value against every request pattern (R2 R3 R6 R7)
    for (int lp = 0; lp < 8; lp++) begin
      for (int p = 1; p < 256; p++) begin
        base_i = 5'(p);
        setlow_i = 1; cmd_line_i = 3'(lp); set_req(8'(p)); step("R7");
        ack_i = 1; step("R3");
        vec_ready_i = 1; step("R5");
        eoi_i = 1; eoi_rot_i = p[0]; step("R6");
        eoi_rot_i = 0;
      end
    end
    set_req(8'h00);

    // Mixed stimulus against the model
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      string tag;
      r = $urandom;
      vec_ready_i = (r[9:8] != 2'd0);
      tag = "R2";
      case (r[2:0])
        3'd0: begin ack_i = 1; tag = "R3"; end
        3'd1: begin poll_i = 1; tag = "R10"; end
        3'd2: begin eoi_i = 1; eoi_spec_i = r[3]; eoi_rot_i = r[4];
                    cmd_line_i = 3'(r[14:12]); tag = r[4] ? "R7" : "R6"; end
        3'd3: begin setlow_i = 1; cmd_line_i = 3'(r[14:12]); tag = "R7"; end
        3'd4: begin mask_we_i = 1; mask_wdata_i = 8'(r[23:16] & r[31:24]); tag = "R11"; end
        3'd5: begin set_req(m_req | 8'(r[23:16])); tag = "R2"; end
        3'd6: begin smm_i = r[5]; aeoi_i = r[6]; aeoi_rot_i = r[7]; tag = "R8"; end
        default: tag = "R5";
      endcase
      step(tag);
      eoi_spec_i = 0; eoi_rot_i = 0;
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule